// File: doc/BRIEF.md
# Forward 4x4 Hadamard Transform Engine

This block takes a 4x4 tile of signed 16-bit coefficients and produces its forward Walsh-Hadamard transform, as used for the second-order transform of the DC terms in a video encoder. The tile arrives one row of four lanes per beat over a valid/ready handshake. When four rows have been taken in, the block stops accepting input, runs the column pass in one cycle, and then returns sixteen signed 16-bit results, one row of four lanes per beat, with a last flag on the fourth beat.

The row pass uses saturating 16-bit butterflies and scales its results by four. The DC term of each row gets a +1 bias when that row's even-lane sum is nonzero. The column pass works at full intermediate width. Each result is rounded toward a fixed scheme and then truncated to 16 bits without clamping. The block holds one tile at a time: a new tile is accepted only after the previous tile's last output row has been taken.

Top module: `wht_fwd4`

## Requirements
- R1: For each input row with lanes i0..i3 (lane j at bits [16j+15:16j]), the row stage forms e=i0+i2, f=i1+i3, g=i0-i2 and h=i1-i3, each clamped to the range -32768..32767.
- R2: The row stage produces four intermediates per row: lane 0 = 4*(e+f), lane 1 = 4*(g+h), lane 2 = 4*(g-h) and lane 3 = 4*(e-f), held at full width with no clamping.
- R3: Lane 0 of a row's intermediates is increased by 1 exactly when that row's e is nonzero. The other three lanes never get this bias.
- R4: For column k, with P, Q, R, S the intermediates of rows 0..3, let u=P+R, v=P-R, w=Q+S and z=Q-S. Output row 0 lane k is u+w, row 1 lane k is v+z, row 2 lane k is v-z, and row 3 lane k is u-w.
- R5: Every output value x is rounded as (x + (x<0 ? 1 : 0) + 3) shifted right arithmetically by 3.
- R6: Each rounded result is delivered as its low 16 bits, with no saturation.
- R7: An input row is taken on a clock edge where inValid and inReady are both high. Rows are taken in order 0..3, and idle cycles between rows do not disturb the tile.
- R8: inReady is low from the edge that takes row 3 until the edge that hands off output row 3. It is high again in the cycle after that hand-off.
- R9: Output rows appear in order 0..3. While outValid is high and outReady is low, outRow and outLast hold their values. outLast is high only with output row 3.
- R10: A synchronous active-high reset discards any partly received tile and clears outValid. After reset, inReady is high and the next row taken is row 0.
- R11: A tile of all-zero inputs produces all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input row valid |
| inReady | output | 1 | Block can take an input row |
| inRow | input | 64 | Four signed 16-bit lanes of one input row |
| outValid | output | 1 | Output row valid |
| outReady | input | 1 | Downstream takes the output row |
| outRow | output | 64 | Four signed 16-bit lanes of one result row |
| outLast | output | 1 | Marks the fourth result row of a tile |

## Verification
The bench builds the block with its default parameters: 16-bit lanes and a 32-bit intermediate width. With 16-bit lanes, full-scale inputs of +32767 and -32768 reach the row-stage clamp directly, and they also drive the rounded results past 16 bits, so truncation of the output is observed. With a 32-bit intermediate, the bench's plain integer model reproduces every stage exactly. Random tiles run with idle input cycles and random output back-pressure, and one tile is cut short by a reset.

// File: rtl/wht_fwd_pkg.sv
package wht_fwd_pkg;
  // Tile edge length; the transform is defined only for four.
  localparam int WHT_N = 4;
  localparam int WHT_IDX_W = $clog2(WHT_N);

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_CALC  = 2'd1,
    ST_DRAIN = 2'd2
  } wht_state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 rowWe;
    logic [WHT_IDX_W-1:0] rowIdx;
    logic                 calcEn;
    logic [WHT_IDX_W-1:0] outIdx;
  } wht_ctl_t;
endpackage

// File: rtl/wht_fwd_rowbfly.sv
module wht_fwd_rowbfly #(
  parameter int DATA_W = 16,
  parameter int MID_W  = 32
) (
  input  logic [wht_fwd_pkg::WHT_N*DATA_W-1:0] rowIn,
  output logic [wht_fwd_pkg::WHT_N*MID_W-1:0]  rowT
);
  localparam int EXT_W = MID_W - DATA_W;

  // Two's-complement add or subtract, clamped to DATA_W bits (R1).
  function automatic logic [DATA_W-1:0] satOp(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic sub);
    logic [DATA_W:0] ex, ey, s;
    ex = {x[DATA_W-1], x};
    ey = {y[DATA_W-1], y};
    s  = sub ? (ex - ey) : (ex + ey);
    if (s[DATA_W] != s[DATA_W-1])
      satOp = s[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      satOp = s[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] lane0, lane1, lane2, lane3;
  logic [DATA_W-1:0] evenSum, oddSum, evenDif, oddDif;
  logic [MID_W-1:0]  xEvenSum, xOddSum, xEvenDif, xOddDif;
  logic              dcBias;

  assign lane0 = rowIn[0*DATA_W +: DATA_W];
  assign lane1 = rowIn[1*DATA_W +: DATA_W];
  assign lane2 = rowIn[2*DATA_W +: DATA_W];
  assign lane3 = rowIn[3*DATA_W +: DATA_W];

  assign evenSum = satOp(lane0, lane2, 1'b0);
  assign oddSum  = satOp(lane1, lane3, 1'b0);
  assign evenDif = satOp(lane0, lane2, 1'b1);
  assign oddDif  = satOp(lane1, lane3, 1'b1);

  assign xEvenSum = {{EXT_W{evenSum[DATA_W-1]}}, evenSum};
  assign xOddSum  = {{EXT_W{oddSum[DATA_W-1]}},  oddSum};
  assign xEvenDif = {{EXT_W{evenDif[DATA_W-1]}}, evenDif};
  assign xOddDif  = {{EXT_W{oddDif[DATA_W-1]}},  oddDif};

  // R3: only the DC lane carries the nonzero bias.
  assign dcBias = (evenSum != '0);

  assign rowT[0*MID_W +: MID_W] = ((xEvenSum + xOddSum) << 2) + MID_W'(dcBias);
  assign rowT[1*MID_W +: MID_W] = (xEvenDif + xOddDif) << 2;
  assign rowT[2*MID_W +: MID_W] = (xEvenDif - xOddDif) << 2;
  assign rowT[3*MID_W +: MID_W] = (xEvenSum - xOddSum) << 2;
endmodule

// File: rtl/wht_fwd_col.sv
module wht_fwd_col #(
  parameter int DATA_W = 16,
  parameter int MID_W  = 32
) (
  input  logic [wht_fwd_pkg::WHT_N*MID_W-1:0]  colIn,
  output logic [wht_fwd_pkg::WHT_N*DATA_W-1:0] colOut
);
  localparam int N = wht_fwd_pkg::WHT_N;

  logic [MID_W-1:0] pTop, qTop, rBot, sBot;
  logic [MID_W-1:0] sumPR, difPR, sumQS, difQS;
  logic [MID_W-1:0] fin [N];

  assign pTop = colIn[0*MID_W +: MID_W];
  assign qTop = colIn[1*MID_W +: MID_W];
  assign rBot = colIn[2*MID_W +: MID_W];
  assign sBot = colIn[3*MID_W +: MID_W];

  assign sumPR = pTop + rBot;
  assign difPR = pTop - rBot;
  assign sumQS = qTop + sBot;
  assign difQS = qTop - sBot;

  // R4: output row order of one column.
  assign fin[0] = sumPR + sumQS;
  assign fin[1] = difPR + difQS;
  assign fin[2] = difPR - difQS;
  assign fin[3] = sumPR - sumQS;

  for (genvar g = 0; g < N; g++) begin : g_round
    logic [MID_W-1:0]        biased;
    logic [2:0]              unusedLo;
    logic [MID_W-DATA_W-4:0] unusedHi;
    logic [DATA_W-1:0]       yTrunc;
    // R5: negative bump, +3, arithmetic shift by 3; R6: keep low bits.
    assign biased = fin[g] + {{(MID_W-1){1'b0}}, fin[g][MID_W-1]} + MID_W'(3);
    assign {unusedHi, yTrunc, unusedLo} = biased;
    assign colOut[g*DATA_W +: DATA_W] = yTrunc;
  end
endmodule

// File: rtl/wht_fwd_ctrl.sv
module wht_fwd_ctrl
  import wht_fwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output logic     outLast,
  output wht_ctl_t ctl
);
  localparam logic [WHT_IDX_W-1:0] LAST_IDX = WHT_IDX_W'(WHT_N - 1);

  wht_state_e           state;
  logic [WHT_IDX_W-1:0] rowCnt;
  logic [WHT_IDX_W-1:0] outCnt;
  logic                 take;

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_DRAIN);
  assign outLast  = outValid && (outCnt == LAST_IDX);
  assign take     = inValid && inReady;

  always_comb begin
    ctl        = '0;
    ctl.rowWe  = take;
    ctl.rowIdx = rowCnt;
    ctl.calcEn = (state == ST_CALC);
    ctl.outIdx = outCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_LOAD;
      rowCnt <= '0;
      outCnt <= '0;
    end else begin
      unique case (state)
        ST_LOAD: if (take) begin
          rowCnt <= rowCnt + 1'b1;
          if (rowCnt == LAST_IDX) state <= ST_CALC;
        end
        ST_CALC: begin
          outCnt <= '0;
          state  <= ST_DRAIN;
        end
        ST_DRAIN: if (outReady) begin
          outCnt <= outCnt + 1'b1;
          if (outCnt == LAST_IDX) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/wht_fwd_dpath.sv
module wht_fwd_dpath
  import wht_fwd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MID_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wht_ctl_t                ctl,
  input  logic [WHT_N*DATA_W-1:0] inRow,
  output logic [WHT_N*DATA_W-1:0] outRow
);
  logic [WHT_N*MID_W-1:0]  rowT;
  logic [MID_W-1:0]        tMem   [WHT_N][WHT_N];
  logic [WHT_N*DATA_W-1:0] colY   [WHT_N];
  logic [WHT_N*DATA_W-1:0] resRow [WHT_N];

  wht_fwd_rowbfly #(.DATA_W(DATA_W), .MID_W(MID_W)) u_row (
    .rowIn (inRow),
    .rowT  (rowT)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < WHT_N; r++)
        for (int j = 0; j < WHT_N; j++) tMem[r][j] <= '0;
    end else if (ctl.rowWe) begin
      for (int j = 0; j < WHT_N; j++) tMem[ctl.rowIdx][j] <= rowT[j*MID_W +: MID_W];
    end
  end

  for (genvar k = 0; k < WHT_N; k++) begin : g_col
    logic [WHT_N*MID_W-1:0] colIn;
    for (genvar r = 0; r < WHT_N; r++) begin : g_gather
      assign colIn[r*MID_W +: MID_W] = tMem[r][k];
    end
    wht_fwd_col #(.DATA_W(DATA_W), .MID_W(MID_W)) u_col (
      .colIn  (colIn),
      .colOut (colY[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < WHT_N; r++) resRow[r] <= '0;
    end else if (ctl.calcEn) begin
      for (int r = 0; r < WHT_N; r++)
        for (int k = 0; k < WHT_N; k++)
          resRow[r][k*DATA_W +: DATA_W] <= colY[k][r*DATA_W +: DATA_W];
    end
  end

  assign outRow = resRow[ctl.outIdx];
endmodule

// File: rtl/wht_fwd4.sv
module wht_fwd4 #(
  parameter int DATA_W = 16,
  parameter int MID_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [4*DATA_W-1:0]   inRow,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [4*DATA_W-1:0]   outRow,
  output logic                  outLast
);
  wht_fwd_pkg::wht_ctl_t ctl;

  wht_fwd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .ctl      (ctl)
  );

  wht_fwd_dpath #(.DATA_W(DATA_W), .MID_W(MID_W)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .inRow  (inRow),
    .outRow (outRow)
  );
endmodule

// File: rtl/wht_fwd_chk.sv
module wht_fwd_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                inReady,
  input logic                outValid,
  input logic                outReady,
  input logic [4*DATA_W-1:0] outRow,
  input logic                outLast
);
  logic [1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else if (outValid && outReady) beat <= beat + 1'b1;
  end

  // R8: no input is taken while results are pending.
  a_r8_closed_while_draining: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  // R8: input reopens right after the final hand-off.
  a_r8_reopen_after_last: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast && outReady) |=> (inReady && !outValid));

  // R9: held output under back-pressure.
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outRow) && $stable(outLast)));

  // R9: last flag marks the fourth beat of a tile only.
  a_r9_last_on_fourth: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outLast == (beat == 2'd3)));

  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);
endmodule

bind wht_fwd4 wht_fwd_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outRow   (outRow),
  .outLast  (outLast)
);

// File: tb/wht_fwd4_tb_top.sv
`timescale 1ns/1ps
module wht_fwd4_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inRow = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outRow;
  logic        outLast;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int blk [16];

  always #10 clk = ~clk;

  wht_fwd4 dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inRow(inRow),
    .outValid(outValid), .outReady(outReady), .outRow(outRow), .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd16(input int v);
    int t;
    t = v + ((v < 0) ? 1 : 0) + 3;
    t = t >>> 3;
    return int'(shortint'(t));
  endfunction

  // Reference: R1 R2 R3 R4 R5 R6 written from the requirements.
  function automatic void refModel(input int x[16], output int y[16]);
    int t [4][4];
    for (int r = 0; r < 4; r++) begin
      int e, f, g, h;
      e = sat16(x[4*r] + x[4*r+2]);
      f = sat16(x[4*r+1] + x[4*r+3]);
      g = sat16(x[4*r] - x[4*r+2]);
      h = sat16(x[4*r+1] - x[4*r+3]);
      t[r][0] = 4*(e+f) + ((e != 0) ? 1 : 0);
      t[r][1] = 4*(g+h);
      t[r][2] = 4*(g-h);
      t[r][3] = 4*(e-f);
    end
    for (int k = 0; k < 4; k++) begin
      int u, v, w, z;
      u = t[0][k] + t[2][k];
      v = t[0][k] - t[2][k];
      w = t[1][k] + t[3][k];
      z = t[1][k] - t[3][k];
      y[k]    = rnd16(u + w);
      y[4+k]  = rnd16(v + z);
      y[8+k]  = rnd16(v - z);
      y[12+k] = rnd16(u - w);
    end
  endfunction

  task automatic sendRows(input int nRows, input bit gaps);
    for (int r = 0; r < nRows; r++) begin
      if (gaps && ($urandom % 2 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      for (int j = 0; j < 4; j++) inRow[16*j +: 16] = 16'(blk[4*r+j]);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inRow   = '0;
  endtask

  task automatic runBlock(input string name, input bit bp, input bit gaps);
    int exp [16];
    logic [63:0] held;
    bit holding;
    holding = 1'b0;
    held = '0;
    refModel(blk, exp);
    sendRows(4, gaps);                       // R7
    for (int r = 0; r < 4; r++) begin
      bit done;
      done = 1'b0;
      while (!done) begin
        outReady = bp ? ($urandom % 3 != 0) : 1'b1;
        if (outValid) begin
          chk(!inReady, "R8", {name, " inReady while draining"}, inReady, 0);
          if (holding)
            chk(outRow == held, "R9", {name, " row held under back-pressure"}, outRow[15:0], held[15:0]);
          if (outReady) begin
            for (int k = 0; k < 4; k++)
              chk(outRow[16*k +: 16] == 16'(exp[4*r+k]), "R4 R5 R6",
                  $sformatf("%s row %0d lane %0d", name, r, k),
                  shortint'(outRow[16*k +: 16]), exp[4*r+k]);
            chk(outLast == (r == 3), "R9", $sformatf("%s outLast row %0d", name, r),
                outLast, (r == 3));
            done = 1'b1;
            holding = 1'b0;
          end else begin
            held = outRow;
            holding = 1'b1;
          end
        end
        @(negedge clk);
      end
    end
    outReady = 1'b0;
    chk(inReady && !outValid, "R8", {name, " input reopens after last"}, inReady, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(inReady == 1'b1, "R10", "inReady after reset", inReady, 1);
    chk(outValid == 1'b0, "R10", "outValid after reset", outValid, 0);
  endtask

  task automatic testZero();
    for (int i = 0; i < 16; i++) blk[i] = 0;
    runBlock("R11 zero tile", 1'b0, 1'b0);
  endtask

  task automatic testMaxPos();
    for (int i = 0; i < 16; i++) blk[i] = 32767;
    runBlock("R1 R6 max positive", 1'b0, 1'b0);
  endtask

  task automatic testMaxNeg();
    for (int i = 0; i < 16; i++) blk[i] = -32768;
    runBlock("R1 R6 max negative", 1'b1, 1'b0);
  endtask

  task automatic testMixedSat();
    for (int i = 0; i < 16; i++) blk[i] = (i % 2 == 0) ? 32767 : -32768;
    blk[2] = -32768; blk[6] = -32768;
    runBlock("R1 mixed saturation", 1'b1, 1'b1);
  endtask

  task automatic testBias();
    // R3: rows with zero even sum but nonzero other terms, and the reverse.
    int pat [16] = '{5, 1, -5, 0,  3, 2, -3, -2,  7, 0, 0, 0,  0, 4, 0, 9};
    blk = pat;
    runBlock("R3 dc bias", 1'b0, 1'b0);
  endtask

  task automatic testAbortReset();
    // R10: a partly received tile is dropped by reset.
    for (int i = 0; i < 16; i++) blk[i] = 1000 + i;
    sendRows(2, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(inReady == 1'b1, "R10", "inReady after mid-tile reset", inReady, 1);
    for (int i = 0; i < 16; i++) blk[i] = 3*i - 20;
    runBlock("R10 tile after abort", 1'b0, 1'b0);
  endtask

  task automatic testRandom(input int n);
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < 16; i++)
        blk[i] = (b % 2 == 0) ? int'(shortint'($urandom)) : (int'($urandom % 512) - 256);
      runBlock($sformatf("R7 R9 random %0d", b), 1'b1, 1'b1);
    end
  endtask

  initial begin
    testReset();
    testZero();
    testMaxPos();
    testMaxNeg();
    testMixedSat();
    testBias();
    testAbortReset();
    testRandom(24);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule